// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit device virtual address into a physical address by reading a two-level translation table from memory. A client offers one address at a time; the walker fetches the first-level word that the top twelve address bits select, and from its two low bits decides one of three things. The word may map a whole 1 MB section. It may point to a 256-word second-level table. It may mark a fault. A second-level word in turn maps a 4 KB small page, maps a 64 KB large page, or marks a fault. Large pages are described by sixteen identical consecutive second-level words, so any of them gives the same frame.

The first-level table base is held in a register inside the walker and is loaded through a write strobe. Memory is reached through a plain read port. The walker raises a one-cycle request with a word address. Some later cycle a response strobe returns the data. Each walk ends with a one-cycle result strobe that carries the physical address, a size code, a fault flag and, on a fault, the offending virtual address.

Top module: `xlat_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` and `mem_req` are 0.
- R2: The first read of a walk is at the table base (bits 31:14 of the base register) plus 4 times virtual address bits 31:20.
- R3: A first-level word whose bits 1:0 are 00 or 11 ends the walk as a fault after a single read.
- R4: A first-level word with bits 1:0 = 10 is a section. The result is word bits 31:20 followed by address bits 19:0, with size code 3, after a single read.
- R5: A first-level word with bits 1:0 = 01 causes a second read at (word AND 0xFFFFFC00) plus 4 times address bits 19:12.
- R6: A second-level word with bits 1:0 = 00 ends the walk as a fault after two reads.
- R7: A second-level word with bits 1:0 = 01 is a 64 KB page. The result is word bits 31:16 followed by address bits 15:0, with size code 2. Any of the sixteen replicated words gives the same frame.
- R8: A second-level word with bit 1 set (10 or 11) is a 4 KB page. The result is word bits 31:12 followed by address bits 11:0, with size code 1.
- R9: On any fault, `rsp_fault` is 1, `rsp_paddr` is 0, the size code is 0, and `rsp_fault_vaddr` equals the walked virtual address. It is 0 on a successful walk.
- R10: Only one walk runs at a time. While a walk is in progress `req_ready` is 0, `req_valid` is ignored, and no walk issues more than two reads. `rsp_valid` is a one-cycle pulse.
- R11: A write on `base_wr` loads the base register with bits 13:0 forced to zero. Later walks use the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| base_wr | input | 1 | Load strobe for the first-level base register |
| base_wdata | input | 32 | New base value; bits 13:0 are dropped |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| mem_req | output | 1 | One-cycle table read request |
| mem_addr | output | 32 | Word address of the table read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Table word read |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_size | output | 2 | 0 fault, 1 4 KB, 2 64 KB, 3 1 MB |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_fault_vaddr | output | 32 | Faulting virtual address, 0 otherwise |

## Verification
Translations are run against a small table image covering every entry type: a section, both first-level fault codes, a pointer whose second level holds small pages with bits 1:0 of 10 and of 11, a replicated large page, and an empty slot. Each walk checks the result, the number of reads and their addresses. Comparing results shows whether the size decode and the offset merge are right. The read addresses show whether the index extraction and the base and pointer masks are right. Two addresses in the same 64 KB region that hit different replicas must produce the same frame. A reloaded base with low bits set shows that those bits are masked. A request held up during a walk must leave the read count and the result untouched.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int XW         = 32;  // address and entry width
  localparam int SECT_SH    = 20;  // 1 MB section offset bits
  localparam int LARGE_SH   = 16;  // 64 KB page offset bits
  localparam int SMALL_SH   = 12;  // 4 KB page offset bits
  localparam int L2PTR_SH   = 10;  // second-level table alignment
  localparam int L1ALIGN_SH = 14;  // first-level table alignment
  localparam int WORD_SH    = 2;   // byte offset of a 32-bit word
  localparam int L1_IDX_W   = XW - SECT_SH;
  localparam int L2_IDX_W   = SECT_SH - SMALL_SH;

  typedef enum logic [1:0] {
    SZ_NONE    = 2'd0,
    SZ_SMALL   = 2'd1,
    SZ_LARGE   = 2'd2,
    SZ_SECTION = 2'd3
  } pg_size_e;

  typedef enum logic [1:0] {
    L1K_FAULT   = 2'd0,
    L1K_TABLE   = 2'd1,
    L1K_SECTION = 2'd2
  } l1_kind_e;

  function automatic logic [XW-1:0] keep_hi(input logic [XW-1:0] v, input int sh);
    logic [XW-1:0] m;
    m = '1;
    m = m << sh;
    return v & m;
  endfunction

  function automatic logic [XW-1:0] keep_lo(input logic [XW-1:0] v, input int sh);
    logic [XW-1:0] m;
    m = '1;
    m = ~(m << sh);
    return v & m;
  endfunction

  function automatic logic [XW-1:0] l1_read_addr(input logic [XW-1:0] base,
                                                 input logic [XW-1:0] va);
    logic [XW-1:0] idx;
    idx = va >> SECT_SH;
    return keep_hi(base, L1ALIGN_SH) | (idx << WORD_SH);
  endfunction

  function automatic logic [XW-1:0] l2_read_addr(input logic [XW-1:0] ptr,
                                                 input logic [XW-1:0] va);
    logic [XW-1:0] idx;
    idx = keep_lo(va, SECT_SH) >> SMALL_SH;
    return keep_hi(ptr, L2PTR_SH) | (idx << WORD_SH);
  endfunction

  function automatic logic [XW-1:0] join_pa(input logic [XW-1:0] ent,
                                            input logic [XW-1:0] va,
                                            input int sh);
    return keep_hi(ent, sh) | keep_lo(va, sh);
  endfunction

endpackage

// File: rtl/xlat_l1_dec.sv
module xlat_l1_dec
  import xlat_pkg::*;
(
  input  logic [1:0] code,
  output l1_kind_e   kind
);
  always_comb begin
    unique case (code)
      2'b01:   kind = L1K_TABLE;
      2'b10:   kind = L1K_SECTION;
      default: kind = L1K_FAULT;
    endcase
  end
endmodule

// File: rtl/xlat_l2_dec.sv
module xlat_l2_dec
  import xlat_pkg::*;
(
  input  logic [XW-1:0] ent,
  input  logic [XW-1:0] va,
  output logic          fault,
  output pg_size_e      size,
  output logic [XW-1:0] pa
);
  always_comb begin
    if (ent[1]) begin
      fault = 1'b0;
      size  = SZ_SMALL;
      pa    = join_pa(ent, va, SMALL_SH);
    end else if (ent[0]) begin
      fault = 1'b0;
      size  = SZ_LARGE;
      pa    = join_pa(ent, va, LARGE_SH);
    end else begin
      fault = 1'b1;
      size  = SZ_NONE;
      pa    = '0;
    end
  end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_wr,
  input  logic [31:0]   base_wdata,
  input  logic          req_valid,
  input  logic [31:0]   req_vaddr,
  output logic          req_ready,
  output logic          mem_req,
  output logic [31:0]   mem_addr,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_data,
  output logic          rsp_valid,
  output logic          rsp_fault,
  output logic [1:0]    rsp_size,
  output logic [31:0]   rsp_paddr,
  output logic [31:0]   rsp_fault_vaddr
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_RD, ST_L1_WT, ST_L2_RD, ST_L2_WT, ST_DONE
  } walk_st_e;

  walk_st_e       state;
  logic [XW-1:0]  base_q, va_q, l1e_q;
  pg_size_e       size_q;

  // named internal events
  logic           walk_accept;
  logic           l1_arrive, l2_arrive;
  l1_kind_e       l1_kind;
  logic           l2_fault;
  pg_size_e       l2_size;
  logic [XW-1:0]  l2_pa;

  assign req_ready   = (state == ST_IDLE);
  assign walk_accept = req_valid && req_ready;
  assign l1_arrive   = (state == ST_L1_WT) && mem_rsp_valid;
  assign l2_arrive   = (state == ST_L2_WT) && mem_rsp_valid;
  assign mem_req     = (state == ST_L1_RD) || (state == ST_L2_RD);
  assign mem_addr    = (state == ST_L2_RD) ? l2_read_addr(l1e_q, va_q)
                                           : l1_read_addr(base_q, va_q);
  assign rsp_valid   = (state == ST_DONE);
  assign rsp_size    = size_q;

  xlat_l1_dec u_l1 (.code(mem_rsp_data[1:0]), .kind(l1_kind));

  xlat_l2_dec u_l2 (
    .ent(mem_rsp_data), .va(va_q),
    .fault(l2_fault), .size(l2_size), .pa(l2_pa)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state           <= ST_IDLE;
      base_q          <= '0;
      va_q            <= '0;
      l1e_q           <= '0;
      size_q          <= SZ_NONE;
      rsp_fault       <= 1'b0;
      rsp_paddr       <= '0;
      rsp_fault_vaddr <= '0;
    end else begin
      if (base_wr) base_q <= keep_hi(base_wdata, L1ALIGN_SH);
      unique case (state)
        ST_IDLE: if (walk_accept) begin
          va_q  <= req_vaddr;
          state <= ST_L1_RD;
        end
        ST_L1_RD: state <= ST_L1_WT;
        ST_L1_WT: if (l1_arrive) begin
          unique case (l1_kind)
            L1K_SECTION: begin
              size_q          <= SZ_SECTION;
              rsp_fault       <= 1'b0;
              rsp_paddr       <= join_pa(mem_rsp_data, va_q, SECT_SH);
              rsp_fault_vaddr <= '0;
              state           <= ST_DONE;
            end
            L1K_TABLE: begin
              l1e_q <= mem_rsp_data;
              state <= ST_L2_RD;
            end
            default: begin
              size_q          <= SZ_NONE;
              rsp_fault       <= 1'b1;
              rsp_paddr       <= '0;
              rsp_fault_vaddr <= va_q;
              state           <= ST_DONE;
            end
          endcase
        end
        ST_L2_RD: state <= ST_L2_WT;
        ST_L2_WT: if (l2_arrive) begin
          size_q          <= l2_size;
          rsp_fault       <= l2_fault;
          rsp_paddr       <= l2_pa;
          rsp_fault_vaddr <= l2_fault ? va_q : '0;
          state           <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        walk_accept,
  input logic [31:0] req_vaddr,
  input logic        req_ready,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        rsp_valid,
  input logic        rsp_fault,
  input logic [1:0]  rsp_size,
  input logic [31:0] rsp_paddr,
  input logic [31:0] rsp_fault_vaddr
);
  logic [31:0] va_seen;
  logic [1:0]  rd_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_seen <= '0;
      rd_cnt  <= '0;
    end else if (walk_accept) begin
      va_seen <= req_vaddr;
      rd_cnt  <= '0;
    end else if (mem_req && rd_cnt != 2'd3) begin
      rd_cnt <= rd_cnt + 2'd1;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (req_ready && !rsp_valid && !mem_req));

  p_word_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  p_section_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_size == 2'd3) |-> (rsp_paddr[19:0] == va_seen[19:0]));

  p_fault_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == 32'd0 && rsp_size == 2'd0
                                  && rsp_fault_vaddr == va_seen));

  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  p_two_reads_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (rd_cnt < 2'd2));

  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

bind xlat_walker xlat_walker_chk u_chk (.*);

// File: tb/xlat_walker_test.sv
`timescale 1ns/1ps
module xlat_walker_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_wr = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready, mem_req, rsp_valid, rsp_fault;
  logic [31:0] mem_addr, rsp_paddr, rsp_fault_vaddr;
  logic [1:0]  rsp_size;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  xlat_walker uut (.*);

  // memory model: one-cycle latency, logs every read
  logic [31:0] mem [logic [31:0]];
  logic [31:0] rd_log [0:255];
  int          total_rd = 0;

  function automatic logic [31:0] mrd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'd0;
  endfunction

  always @(posedge clk) begin
    mem_rsp_valid <= mem_req;
    mem_rsp_data  <= mrd(mem_addr);
    if (mem_req) begin
      rd_log[total_rd[7:0]] <= mem_addr;
      total_rd <= total_rd + 1;
    end
  end

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // vectors: va, pa, size, fault, reads, first addr, second addr
  localparam int NV = 8;
  localparam logic [31:0] V_VA [0:NV-1] = '{
    32'h0012_3456, 32'h0023_4567, 32'h0030_0010, 32'h0040_5ABC,
    32'h0040_6DEF, 32'h0041_2345, 32'h0041_FEDC, 32'h0040_7000};
  localparam logic [31:0] V_PA [0:NV-1] = '{
    32'hABC2_3456, 32'h0, 32'h0, 32'h8765_4ABC,
    32'h1111_1DEF, 32'h5555_2345, 32'h5555_FEDC, 32'h0};
  localparam logic [1:0] V_SZ [0:NV-1] = '{2'd3, 2'd0, 2'd0, 2'd1, 2'd1, 2'd2, 2'd2, 2'd0};
  localparam logic V_FL [0:NV-1] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam int V_RD [0:NV-1] = '{1, 1, 1, 2, 2, 2, 2, 2};
  localparam logic [31:0] V_A1 [0:NV-1] = '{
    32'h0010_0004, 32'h0010_0008, 32'h0010_000C, 32'h0010_0010,
    32'h0010_0010, 32'h0010_0010, 32'h0010_0010, 32'h0010_0010};
  localparam logic [31:0] V_A2 [0:NV-1] = '{
    32'h0, 32'h0, 32'h0, 32'h0020_0414,
    32'h0020_0418, 32'h0020_0448, 32'h0020_047C, 32'h0020_041C};

  function automatic string vtag(input int i);
    case (i)
      0: return "R4";
      1: return "R3";
      2: return "R3";
      3: return "R8";
      4: return "R8";
      5: return "R7";
      6: return "R7";
      default: return "R6";
    endcase
  endfunction

  logic [31:0] got_pa, got_fva, got_a1, got_a2;
  logic [1:0]  got_sz;
  logic        got_fl, got_ok;
  int          got_rd;

  task automatic load_base(input logic [31:0] v);
    @(negedge clk);
    base_wr = 1'b1; base_wdata = v;
    @(negedge clk);
    base_wr = 1'b0;
  endtask

  task automatic walk(input logic [31:0] va);
    int start;
    @(negedge clk);
    start = total_rd;
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    got_ok = 1'b0;
    for (int k = 0; k < 30; k++) begin
      if (rsp_valid) begin got_ok = 1'b1; break; end
      @(negedge clk);
    end
    got_pa = rsp_paddr; got_sz = rsp_size; got_fl = rsp_fault;
    got_fva = rsp_fault_vaddr;
    got_rd = total_rd - start;
    got_a1 = rd_log[start[7:0]];
    got_a2 = rd_log[8'(start + 1)];
    chk(got_ok, "R10 response", {31'd0, got_ok}, 32'd1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    mem[32'h0010_0004] = 32'hABC0_0002;            // section
    mem[32'h0010_0008] = 32'h0000_0000;            // fault 00
    mem[32'h0010_000C] = 32'h1234_5673;            // fault 11
    mem[32'h0010_0010] = 32'h0020_0401;            // table pointer
    mem[32'h0020_0414] = 32'h8765_4002;            // small, code 10
    mem[32'h0020_0418] = 32'h1111_1003;            // small, code 11
    mem[32'h0020_041C] = 32'h0000_0000;            // L2 fault
    for (int j = 16; j < 32; j++)                  // replicated large page
      mem[32'h0020_0400 + 32'(j * 4)] = 32'h5555_0001;
    mem[32'h0020_0004] = 32'hFEE0_0002;            // section under second base

    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready", {31'd0, req_ready}, 32'd1);
    chk(rsp_valid === 1'b0, "R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk(mem_req === 1'b0, "R1 mem_req", {31'd0, mem_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready after release", {31'd0, req_ready}, 32'd1);

    // R11: low base bits are dropped
    load_base(32'h0010_3FFF);

    for (int i = 0; i < NV; i++) begin
      walk(V_VA[i]);
      chk(got_pa == V_PA[i], {vtag(i), " paddr"}, got_pa, V_PA[i]);
      chk(got_sz == V_SZ[i], {vtag(i), " size"}, {30'd0, got_sz}, {30'd0, V_SZ[i]});
      chk(got_fl == V_FL[i], {vtag(i), " fault"}, {31'd0, got_fl}, {31'd0, V_FL[i]});
      chk(got_fva == (V_FL[i] ? V_VA[i] : 32'd0), "R9 fault vaddr",
          got_fva, V_FL[i] ? V_VA[i] : 32'd0);
      chk(got_rd == V_RD[i], "R10 read count", 32'(got_rd), 32'(V_RD[i]));
      chk(got_a1 == V_A1[i], "R2 first read addr", got_a1, V_A1[i]);
      if (V_RD[i] == 2)
        chk(got_a2 == V_A2[i], "R5 second read addr", got_a2, V_A2[i]);
    end

    // R7: two replicas of one large page give one frame
    walk(32'h0041_0000);
    chk(got_pa == 32'h5555_0000, "R7 replica low", got_pa, 32'h5555_0000);
    walk(32'h0041_F000);
    chk(got_pa == 32'h5555_F000, "R7 replica high", got_pa, 32'h5555_F000);

    // R10: requests during a walk are ignored
    @(negedge clk);
    begin : busy_test
      int start;
      start = total_rd;
      req_valid = 1'b1; req_vaddr = 32'h0012_3456;
      @(negedge clk);
      chk(req_ready === 1'b0, "R10 busy ready", {31'd0, req_ready}, 32'd0);
      req_vaddr = 32'h0040_5ABC;                   // stray request while busy
      @(negedge clk);
      @(negedge clk);
      chk(rsp_valid === 1'b1, "R10 result cycle", {31'd0, rsp_valid}, 32'd1);
      chk(rsp_paddr == 32'hABC2_3456, "R10 result untouched", rsp_paddr, 32'hABC2_3456);
      req_valid = 1'b0;
      @(negedge clk);
      chk(rsp_valid === 1'b0, "R10 pulse", {31'd0, rsp_valid}, 32'd0);
      repeat (6) @(negedge clk);
      chk(total_rd - start == 1, "R10 no stray reads", 32'(total_rd - start), 32'd1);
    end

    // R11: new base takes effect
    load_base(32'h0020_3ABC);
    walk(32'h0010_0001);
    chk(got_a1 == 32'h0020_0004, "R11 base addr", got_a1, 32'h0020_0004);
    chk(got_pa == 32'hFEE0_0001, "R11 paddr", got_pa, 32'hFEE0_0001);

    // R3: unmapped first-level slot under the new base
    walk(32'hFFF0_0000);
    chk(got_fl == 1'b1, "R3 empty slot", {31'd0, got_fl}, 32'd1);
    chk(got_pa == 32'd0, "R9 zero paddr", got_pa, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule